// File: doc/BRIEF.md
# Masked OR Trigger Pulse Shaper

The block forms two trigger outputs from 96 input lines arranged as three groups of 32. Each output has a 3-bit group mask. The mask picks which groups feed a wide OR. A rising edge of that OR starts a one-shot pulse with a programmable high time. A programmable blind interval follows each pulse. During the pulse and the blind interval, input activity is discarded.

Both outputs share the high-time and dead-time fields. These fields do not act directly. A single-cycle output-reset command copies them into internal registers. The same command also returns both shapers to idle with their outputs low. Software must issue this command after power-up and after every change to the timing fields.

Top module: `masked_or_pulse_shaper`

## Requirements
- R1: Mask bit 0 selects inputs 31..0 (group A), bit 1 selects inputs 63..32 (group B) and bit 2 selects inputs 95..64 (group C). An output reacts to the OR of all selected groups only.
- R2: The two outputs are independent, and each one follows only its own mask.
- R3: An output fires on a rising edge of its selected OR. The output is high in the cycle after the clock edge that samples the rise.
- R4: Each pulse lasts N+2 cycles, where N is the captured 4-bit high-time value.
- R5: After each pulse the output stays low and blind for M+2 cycles, where M is the captured 4-bit dead-time value. A rise sampled in the last dead cycle is ignored, and a rise sampled one cycle later fires.
- R6: A selected OR that stays high fires only once. A new pulse needs a new rising edge.
- R7: A change to the high-time or dead-time inputs has no effect until an output reset is issued.
- R8: Output reset forces both outputs low and both shapers to idle from the next cycle on, even in the middle of a pulse.
- R9: After asynchronous reset both outputs are low, and the captured timing values are zero, giving 2-cycle pulses.
- R10: A mask of zero keeps its output low whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chan_i | input | 96 | Enable-masked input lines, group A in the low 32 bits |
| mask_a_i | input | 3 | Group mask for output A |
| mask_b_i | input | 3 | Group mask for output B |
| high_len_i | input | 4 | High-time field N (pulse of N+2 cycles) |
| dead_len_i | input | 4 | Dead-time field M (blind time of M+2 cycles) |
| out_rst_i | input | 1 | Output reset: idles both shapers and captures the timing fields |
| trig_a_o | output | 1 | Shaped trigger A |
| trig_b_o | output | 1 | Shaped trigger B |

## Verification
The group mapping is tested by raising one line in each group under several mask pairs. This separates a correct bit-to-group mapping from a swapped one, and shows that each output follows only its own mask. Pulse widths are measured for high-time values 0, 5 and 15 to expose off-by-one counter loads. The dead interval is probed with a rise one cycle before its end and a rise exactly at its end. Further cases cover a held-high input, a timing change made without an output reset, and an output reset issued in the middle of a pulse. Together these separate edge detection from level detection and confirm that settings act only after capture.

// File: rtl/trig_shaper_pkg.sv
package trig_shaper_pkg;
  localparam int unsigned NUM_GRP = 3;
  localparam int unsigned GRP_W   = 32;
  localparam int unsigned LEN_W   = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_DEAD = 2'd2
  } shp_state_e;
endpackage

// File: rtl/grp_or_select.sv
module grp_or_select #(
  parameter int unsigned NUM_GRP = 3,
  parameter int unsigned GRP_W   = 32,
  localparam int unsigned IN_W   = NUM_GRP * GRP_W
) (
  input  logic [IN_W-1:0]    chan_i,
  input  logic [NUM_GRP-1:0] mask_i,
  output logic               sel_o
);
  logic [NUM_GRP-1:0] grp_any;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_any[g] = |chan_i[g*GRP_W +: GRP_W];
  end

  assign sel_o = |(grp_any & mask_i);

  // R10: empty mask never selects
  always_comb begin
    if (mask_i == '0) a_r10_empty_mask: assert (sel_o == 1'b0);
  end
endmodule

// File: rtl/tim_capture.sv
module tim_capture #(
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] high_len_i,
  input  logic [LEN_W-1:0] dead_len_i,
  output logic [LEN_W-1:0] high_len_o,
  output logic [LEN_W-1:0] dead_len_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      high_len_o <= '0;
      dead_len_o <= '0;
    end else if (load_i) begin
      high_len_o <= high_len_i;
      dead_len_o <= dead_len_i;
    end
  end

  // R7: captured values move only on load
  a_r7_hold_without_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(high_len_o) && $stable(dead_len_o));
endmodule

// File: rtl/trig_one_shot.sv
module trig_one_shot
  import trig_shaper_pkg::*;
#(
  parameter int unsigned LEN_W = 4,
  localparam int unsigned CNT_W = LEN_W + 1,
  localparam int unsigned RUN_W = LEN_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             sel_i,
  input  logic [LEN_W-1:0] high_n_i,
  input  logic [LEN_W-1:0] dead_n_i,
  output logic             pulse_o
);
  shp_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             prev_q, rise;

  assign rise = sel_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sel_i;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (clr_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rise) begin
          state_d = ST_HIGH;
          cnt_d   = CNT_W'(high_n_i) + CNT_W'(1);
        end
        ST_HIGH: if (cnt_q == '0) begin
          state_d = ST_DEAD;
          cnt_d   = CNT_W'(dead_n_i) + CNT_W'(1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
        ST_DEAD: if (cnt_q == '0) state_d = ST_IDLE;
                 else cnt_d = cnt_q - CNT_W'(1);
        default: begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pulse_o = (state_q == ST_HIGH);

  // run-length monitors for the timing assertions
  logic [RUN_W-1:0] hi_run_q, dd_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run_q <= '0;
      dd_run_q <= '0;
    end else begin
      hi_run_q <= (state_q == ST_HIGH) ? hi_run_q + RUN_W'(1) : '0;
      dd_run_q <= (state_q == ST_DEAD) ? dd_run_q + RUN_W'(1) : '0;
    end
  end

  a_r3_fire_needs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !rise) |=> state_q != ST_HIGH);

  a_r4_high_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HIGH && state_d == ST_DEAD) |-> hi_run_q == RUN_W'(high_n_i) + RUN_W'(1));

  a_r5_dead_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEAD && state_d == ST_IDLE && !clr_i) |-> dd_run_q == RUN_W'(dead_n_i) + RUN_W'(1));

  a_r5_no_fire_in_dead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DEAD |=> state_q != ST_HIGH);

  a_r8_clear_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> state_q == ST_IDLE && !pulse_o);
endmodule

// File: rtl/masked_or_pulse_shaper.sv
module masked_or_pulse_shaper
  import trig_shaper_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_GRP*GRP_W-1:0] chan_i,
  input  logic [NUM_GRP-1:0]       mask_a_i,
  input  logic [NUM_GRP-1:0]       mask_b_i,
  input  logic [LEN_W-1:0]         high_len_i,
  input  logic [LEN_W-1:0]         dead_len_i,
  input  logic                     out_rst_i,
  output logic                     trig_a_o,
  output logic                     trig_b_o
);
  localparam int unsigned NUM_OUT = 2;

  logic [NUM_GRP-1:0] mask [NUM_OUT];
  logic [NUM_OUT-1:0] sel, pulse;
  logic [LEN_W-1:0]   high_q, dead_q;

  assign mask[0] = mask_a_i;
  assign mask[1] = mask_b_i;

  tim_capture #(.LEN_W(LEN_W)) i_tim_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (out_rst_i),
    .high_len_i (high_len_i),
    .dead_len_i (dead_len_i),
    .high_len_o (high_q),
    .dead_len_o (dead_q)
  );

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    grp_or_select #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) i_sel (
      .chan_i (chan_i),
      .mask_i (mask[o]),
      .sel_o  (sel[o])
    );
    trig_one_shot #(.LEN_W(LEN_W)) i_shot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (out_rst_i),
      .sel_i    (sel[o]),
      .high_n_i (high_q),
      .dead_n_i (dead_q),
      .pulse_o  (pulse[o])
    );
  end

  assign trig_a_o = pulse[0];
  assign trig_b_o = pulse[1];

  // R2: an output with an empty mask stays low next cycle
  a_r2_b_empty_mask_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_b_i == '0 && !trig_b_o) |=> !trig_b_o);
endmodule

// File: tb/test_masked_or_pulse_shaper.sv
module test_masked_or_pulse_shaper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] chan = '0;
  logic [2:0]  mask_a = '0, mask_b = '0;
  logic [3:0]  high_len = '0, dead_len = '0;
  logic        out_rst = 1'b0;
  logic        trig_a, trig_b;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  masked_or_pulse_shaper i_masked_or_pulse_shaper (
    .clk_i(clk), .rst_ni(rst_n), .chan_i(chan), .mask_a_i(mask_a), .mask_b_i(mask_b),
    .high_len_i(high_len), .dead_len_i(dead_len), .out_rst_i(out_rst),
    .trig_a_o(trig_a), .trig_b_o(trig_b));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    chan = '0;
    repeat (40) @(negedge clk);
  endtask

  task automatic do_orst(int h, int d);
    @(negedge clk);
    high_len = 4'(h); dead_len = 4'(d); out_rst = 1'b1;
    @(negedge clk);
    out_rst = 1'b0;
  endtask

  // entered at the negedge where chan was just raised; returns at first low negedge
  task automatic measure(bit use_b, output int len);
    len = 0;
    @(negedge clk);
    chan = '0;
    while ((use_b ? trig_b : trig_a) && len < 40) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int len;
    chk("R9 trig_a after reset", trig_a, 0);
    chk("R9 trig_b after reset", trig_b, 0);
    mask_a = 3'b001;
    @(negedge clk);
    chan[3] = 1'b1;
    chk("R3 low before sampling edge", trig_a, 0);
    measure(1'b0, len);
    chk("R9 default pulse length", len, 2);
    settle();
  endtask

  task automatic t_mask_map();
    logic [2:0] ma [5] = '{3'd1, 3'd2, 3'd4, 3'd7, 3'd0};
    logic [2:0] mb [5] = '{3'd2, 3'd4, 3'd1, 3'd0, 3'd7};
    do_orst(3, 0);
    for (int p = 0; p < 5; p++) begin
      for (int g = 0; g < 3; g++) begin
        mask_a = ma[p]; mask_b = mb[p];
        @(negedge clk);
        chan[g*32 + 7 + p] = 1'b1;
        @(negedge clk);
        chk("R1 output A group map", trig_a, int'(ma[p][g]));
        chk("R2 output B own mask", trig_b, int'(mb[p][g]));
        if (ma[p] == 3'd0) chk("R10 empty mask A low", trig_a, 0);
        if (mb[p] == 3'd0) chk("R10 empty mask B low", trig_b, 0);
        settle();
      end
    end
  endtask

  task automatic t_high_len();
    int hv [3] = '{0, 5, 15};
    int len;
    mask_a = 3'b100; mask_b = 3'b000;
    foreach (hv[i]) begin
      do_orst(hv[i], 0);
      @(negedge clk);
      chan[90] = 1'b1;
      measure(1'b0, len);
      chk("R4 pulse length", len, hv[i] + 2);
      settle();
    end
  endtask

  task automatic t_dead();
    int len, hits;
    mask_a = 3'b010; mask_b = 3'b010;
    do_orst(1, 4);
    @(negedge clk); chan[40] = 1'b1;
    measure(1'b0, len);
    repeat (4 + 1) @(negedge clk);
    chan[41] = 1'b1;                // sampled in the last dead cycle
    hits = 0;
    repeat (25) begin @(negedge clk); hits += int'(trig_a); end
    chk("R5 rise in last dead cycle ignored", hits, 0);
    chan = '0;
    @(negedge clk); @(negedge clk);
    chan[41] = 1'b1;
    @(negedge clk);
    chk("R5 fresh rise after dead fires", trig_a, 1);
    settle();
    @(negedge clk); chan[40] = 1'b1;
    measure(1'b0, len);
    repeat (4 + 2) @(negedge clk);
    chan[42] = 1'b1;                // sampled first idle cycle
    @(negedge clk);
    chk("R5 rise at end of dead fires", trig_a, 1);
    chk("R5 output B same timing", trig_b, 1);
    settle();
  endtask

  task automatic t_level();
    int rises;
    logic last;
    mask_a = 3'b001; mask_b = 3'b000;
    do_orst(0, 0);
    @(negedge clk); chan[0] = 1'b1;
    rises = 0; last = 1'b0;
    repeat (50) begin
      @(negedge clk);
      if (trig_a && !last) rises++;
      last = trig_a;
    end
    chk("R6 held level fires once", rises, 1);
    settle();
  endtask

  task automatic t_capture();
    int len;
    mask_a = 3'b001; mask_b = 3'b000;
    do_orst(2, 0);
    @(negedge clk); high_len = 4'd9;
    @(negedge clk); chan[1] = 1'b1;
    measure(1'b0, len);
    chk("R7 uncaptured high time ignored", len, 4);
    settle();
    do_orst(9, 0);
    @(negedge clk); chan[1] = 1'b1;
    measure(1'b0, len);
    chk("R7 captured high time applies", len, 11);
    settle();
  endtask

  task automatic t_orst_mid();
    int hits;
    mask_a = 3'b001; mask_b = 3'b100;
    do_orst(10, 0);
    @(negedge clk); chan[2] = 1'b1; chan[70] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 both high before reset", int'(trig_a & trig_b), 1);
    out_rst = 1'b1;
    @(negedge clk);
    out_rst = 1'b0;
    chk("R8 trig_a low after reset", trig_a, 0);
    chk("R8 trig_b low after reset", trig_b, 0);
    hits = 0;
    repeat (20) begin @(negedge clk); hits += int'(trig_a | trig_b); end
    chk("R8 no restart while level held", hits, 0);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_map();
    t_high_len();
    t_dead();
    t_level();
    t_capture();
    t_orst_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule